// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This block decides, once per reset, whether the chip boots into ordinary user mode or into a debug monitor mode, and then applies the consequences of that choice. There are two ways into monitor mode. The first is a high-voltage level detected on the interrupt pin together with a required pattern on the mode-select pins. The second needs no high voltage: it applies when both reset-vector bytes held in flash read as erased (all ones). The second path exists for in-circuit programming of blank parts.

Once the mode is fixed, the block does three things. It moves the reset, break and software-interrupt vector fetches into a separate monitor vector window. It chooses whether the internal clock source is the raw oscillator or the oscillator divided by two; a strap pin held low at entry selects the raw oscillator. It also holds the watchdog off while the monitor runs, until the high voltage is taken away from the interrupt pin or the reset pin. The CPU start is withheld by a request/valid handshake with the flash until the two vector bytes have been read and the decision is complete.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The interrupt-pin high-voltage flag, the mode-select pins and the clock strap are sampled on one clock edge only: the third rising edge after rst_n is released, which is the first edge after the internal reset synchronizer lets go. Later changes on these pins do not alter mon_mode or clk_bypass.
- R2: With the high-voltage flag high and mode_sel equal to MODE_REQ (default 2'b10) at the sample edge, mon_mode is 1 once cpu_go rises.
- R3: With both vector bytes equal to 8'hFF when vec_valid is accepted, mon_mode is 1 whatever the high-voltage flag is. Any other byte pair, with no valid high-voltage entry, gives mon_mode 0.
- R4: After the sample edge, vec_req is 1 and cpu_go stays 0 until vec_valid is seen high. On the edge that accepts vec_valid, cpu_go rises, vec_req falls and the mode is decided.
- R5: clk_bypass is 1 (raw oscillator) only when monitor mode is entered and clk_strap_n was 0 at the sample edge. Otherwise it is 0 (divided clock).
- R6: In monitor mode, a cpu_addr of 16'hFFFC to 16'hFFFF comes out on vec_addr as 16'hFEFC to 16'hFEFF. The low two bits are kept, so break and software interrupt still share one pair.
- R7: Every other address, and every address in user mode, passes to vec_addr unchanged.
- R8: In monitor mode, wdog_en is 0 until the interrupt-pin or reset-pin high-voltage flag falls from 1 to 0. From the following cycle it equals NOT cfg_wd_dis.
- R9: In user mode, once cpu_go is 1, wdog_en equals NOT cfg_wd_dis. Before cpu_go, wdog_en is 0.
- R10: mon_mode, clk_bypass and cpu_go hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_irq | input | 1 | High-voltage detect on interrupt pin |
| hv_rst | input | 1 | High-voltage detect on reset pin |
| mode_sel | input | MODE_W | Mode-select pin levels |
| clk_strap_n | input | 1 | Clock-divider bypass strap, low = bypass |
| vec_req | output | 1 | Request for the reset-vector bytes |
| vec_valid | input | 1 | Both vector bytes are present |
| vec_byte_hi | input | DATA_W | Reset-vector high byte from flash |
| vec_byte_lo | input | DATA_W | Reset-vector low byte from flash |
| cfg_wd_dis | input | 1 | Configuration watchdog-disable bit |
| cpu_addr | input | ADDR_W | CPU fetch address |
| cpu_go | output | 1 | CPU may start |
| mon_mode | output | 1 | Monitor mode active |
| clk_bypass | output | 1 | 1 = raw oscillator, 0 = divided by two |
| wdog_en | output | 1 | Watchdog enable |
| vec_addr | output | ADDR_W | Remapped fetch address |

## Verification
Several properties are checked on every cycle. The CPU stays held while a request is outstanding and unanswered. The mode, the clock select and the start flag never change once running. Bypass never appears without monitor mode. Outside monitor mode, addresses pass through untouched and the watchdog follows the configuration bit. Inside monitor mode, the vector window always lands in the monitor page. Only the bench scenarios can show the rest: that the pins are sampled on the right edge and ignored afterwards, that the erased-vector and high-voltage paths each decide the mode correctly, and that the watchdog arms on removal of either high voltage.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;
  typedef enum logic [1:0] {
    BOOT_SAMPLE = 2'd0,
    BOOT_WAIT   = 2'd1,
    BOOT_RUN    = 2'd2
  } boot_st_e;
endpackage

// File: rtl/mon_rst_sync.sv
module mon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mon_entry_seq.sv
module mon_entry_seq
  import mon_entry_pkg::*;
#(
  parameter int              MODE_W   = 2,
  parameter logic [MODE_W-1:0] MODE_REQ = 2'b10,
  parameter int              DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_irq,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              clk_strap_n,
  input  logic              vec_valid,
  input  logic [DATA_W-1:0] vec_byte_hi,
  input  logic [DATA_W-1:0] vec_byte_lo,
  output logic              vec_req,
  output logic              cpu_go,
  output logic              mon_mode,
  output logic              clk_bypass
);
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  boot_st_e st_q, st_d;
  logic hv_ok_q, hv_ok_d;
  logic strap_q, strap_d;
  logic mon_q, mon_d;
  logic byp_q, byp_d;
  logic samp_en, dec_en;
  logic erased;

  assign erased  = (vec_byte_hi == ERASED) && (vec_byte_lo == ERASED);
  assign samp_en = (st_q == BOOT_SAMPLE);
  assign dec_en  = (st_q == BOOT_WAIT) && vec_valid;

  always_comb begin
    st_d    = st_q;
    hv_ok_d = hv_ok_q;
    strap_d = strap_q;
    mon_d   = mon_q;
    byp_d   = byp_q;
    unique case (st_q)
      BOOT_SAMPLE: begin
        hv_ok_d = hv_irq && (mode_sel == MODE_REQ);
        strap_d = clk_strap_n;
        st_d    = BOOT_WAIT;
      end
      BOOT_WAIT: begin
        if (vec_valid) begin
          mon_d = hv_ok_q || erased;
          byp_d = (hv_ok_q || erased) && !strap_q;
          st_d  = BOOT_RUN;
        end
      end
      default: st_d = BOOT_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BOOT_SAMPLE;
      hv_ok_q <= 1'b0;
      strap_q <= 1'b1;
      mon_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (samp_en) begin
        hv_ok_q <= hv_ok_d;
        strap_q <= strap_d;
      end
      if (dec_en) begin
        mon_q <= mon_d;
        byp_q <= byp_d;
      end
    end
  end

  assign vec_req    = (st_q == BOOT_WAIT);
  assign cpu_go     = (st_q == BOOT_RUN);
  assign mon_mode   = mon_q;
  assign clk_bypass = byp_q;
endmodule

// File: rtl/mon_wdog_gate.sv
module mon_wdog_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mon_mode,
  input  logic hv_irq,
  input  logic hv_rst,
  input  logic cfg_wd_dis,
  output logic wdog_en
);
  logic prev_irq_q, prev_rst_q;
  logic armed_q, armed_d;
  logic hv_gone;

  assign hv_gone = (prev_irq_q && !hv_irq) || (prev_rst_q && !hv_rst);

  always_comb begin
    armed_d = armed_q;
    if (run && mon_mode && hv_gone) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_irq_q <= 1'b0;
      prev_rst_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      prev_irq_q <= hv_irq;
      prev_rst_q <= hv_rst;
      armed_q    <= armed_d;
    end
  end

  assign wdog_en = run && !cfg_wd_dis && (!mon_mode || armed_q);
endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap #(
  parameter int                ADDR_W    = 16,
  parameter int                SPAN_LG   = 2,
  parameter logic [ADDR_W-1:0] USER_BASE = 16'hFFFC,
  parameter logic [ADDR_W-1:0] MON_BASE  = 16'hFEFC
) (
  input  logic              mon_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int TAG_W = ADDR_W - SPAN_LG;
  localparam logic [TAG_W-1:0] USER_TAG = USER_BASE[ADDR_W-1:SPAN_LG];
  localparam logic [TAG_W-1:0] MON_TAG  = MON_BASE[ADDR_W-1:SPAN_LG];

  logic hit;

  assign hit = (addr_in[ADDR_W-1:SPAN_LG] == USER_TAG);

  always_comb begin
    addr_out = addr_in;
    if (mon_mode && hit) addr_out = {MON_TAG, addr_in[SPAN_LG-1:0]};
  end
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int                MODE_W    = 2,
  parameter logic [MODE_W-1:0] MODE_REQ  = 2'b10,
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 16,
  parameter int                SPAN_LG   = 2,
  parameter logic [ADDR_W-1:0] USER_BASE = 16'hFFFC,
  parameter logic [ADDR_W-1:0] MON_BASE  = 16'hFEFC,
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_irq,
  input  logic              hv_rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              clk_strap_n,
  output logic              vec_req,
  input  logic              vec_valid,
  input  logic [DATA_W-1:0] vec_byte_hi,
  input  logic [DATA_W-1:0] vec_byte_lo,
  input  logic              cfg_wd_dis,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_go,
  output logic              mon_mode,
  output logic              clk_bypass,
  output logic              wdog_en,
  output logic [ADDR_W-1:0] vec_addr
);
  logic rst_n_i;

  mon_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  mon_entry_seq #(
    .MODE_W   (MODE_W),
    .MODE_REQ (MODE_REQ),
    .DATA_W   (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .hv_irq      (hv_irq),
    .mode_sel    (mode_sel),
    .clk_strap_n (clk_strap_n),
    .vec_valid   (vec_valid),
    .vec_byte_hi (vec_byte_hi),
    .vec_byte_lo (vec_byte_lo),
    .vec_req     (vec_req),
    .cpu_go      (cpu_go),
    .mon_mode    (mon_mode),
    .clk_bypass  (clk_bypass)
  );

  mon_wdog_gate u_wdog (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .run        (cpu_go),
    .mon_mode   (mon_mode),
    .hv_irq     (hv_irq),
    .hv_rst     (hv_rst),
    .cfg_wd_dis (cfg_wd_dis),
    .wdog_en    (wdog_en)
  );

  mon_vec_remap #(
    .ADDR_W    (ADDR_W),
    .SPAN_LG   (SPAN_LG),
    .USER_BASE (USER_BASE),
    .MON_BASE  (MON_BASE)
  ) u_remap (
    .mon_mode (mon_mode),
    .addr_in  (cpu_addr),
    .addr_out (vec_addr)
  );
endmodule

// File: rtl/mon_entry_chk.sv
module mon_entry_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                SPAN_LG   = 2,
  parameter logic [ADDR_W-1:0] USER_BASE = 16'hFFFC,
  parameter logic [ADDR_W-1:0] MON_BASE  = 16'hFEFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_req,
  input logic              vec_valid,
  input logic              cfg_wd_dis,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_go,
  input logic              mon_mode,
  input logic              clk_bypass,
  input logic              wdog_en,
  input logic [ADDR_W-1:0] vec_addr
);
  localparam int TAG_W = ADDR_W - SPAN_LG;
  localparam logic [TAG_W-1:0] USER_TAG = USER_BASE[ADDR_W-1:SPAN_LG];
  localparam logic [TAG_W-1:0] MON_TAG  = MON_BASE[ADDR_W-1:SPAN_LG];

  a_r4_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_valid) |=> !cpu_go);

  a_r4_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_req && cpu_go));

  a_r10_go_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |=> cpu_go);

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |=> ($stable(mon_mode) && $stable(clk_bypass)));

  a_r5_bypass_needs_mon: assert property (@(posedge clk) disable iff (!rst_n)
    clk_bypass |-> mon_mode);

  a_r6_window_moved: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_mode && cpu_addr[ADDR_W-1:SPAN_LG] == USER_TAG) |->
      (vec_addr[ADDR_W-1:SPAN_LG] == MON_TAG &&
       vec_addr[SPAN_LG-1:0] == cpu_addr[SPAN_LG-1:0]));

  a_r7_user_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_mode |-> (vec_addr == cpu_addr));

  a_r9_user_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && !mon_mode) |-> (wdog_en == !cfg_wd_dis));

  a_r9_idle_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_go |-> !wdog_en);

  a_r8_cfg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wd_dis |-> !wdog_en);
endmodule

bind mon_entry_ctrl mon_entry_chk #(
  .ADDR_W    (ADDR_W),
  .SPAN_LG   (SPAN_LG),
  .USER_BASE (USER_BASE),
  .MON_BASE  (MON_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vec_req    (vec_req),
  .vec_valid  (vec_valid),
  .cfg_wd_dis (cfg_wd_dis),
  .cpu_addr   (cpu_addr),
  .cpu_go     (cpu_go),
  .mon_mode   (mon_mode),
  .clk_bypass (clk_bypass),
  .wdog_en    (wdog_en),
  .vec_addr   (vec_addr)
);

// File: tb/mon_entry_ctrl_bench.sv
module mon_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hv_irq, hv_rst, clk_strap_n, vec_valid, cfg_wd_dis;
  logic [1:0]  mode_sel;
  logic [7:0]  vec_byte_hi, vec_byte_lo;
  logic [15:0] cpu_addr;
  logic        vec_req, cpu_go, mon_mode, clk_bypass, wdog_en;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mon_entry_ctrl u_mon_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .hv_irq(hv_irq), .hv_rst(hv_rst),
    .mode_sel(mode_sel), .clk_strap_n(clk_strap_n), .vec_req(vec_req),
    .vec_valid(vec_valid), .vec_byte_hi(vec_byte_hi), .vec_byte_lo(vec_byte_lo),
    .cfg_wd_dis(cfg_wd_dis), .cpu_addr(cpu_addr), .cpu_go(cpu_go),
    .mon_mode(mon_mode), .clk_bypass(clk_bypass), .wdog_en(wdog_en),
    .vec_addr(vec_addr)
  );

  function automatic bit exp_mon(bit hv, logic [1:0] ms, logic [7:0] hi, logic [7:0] lo);
    return (hv && ms == 2'b10) || (hi == 8'hFF && lo == 8'hFF);
  endfunction

  function automatic logic [15:0] exp_addr(bit mon, logic [15:0] a);
    if (mon && a[15:2] == 14'h3FFF) return {8'hFE, a[7:0]};
    return a;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic scenario(bit hv, bit hvr, logic [1:0] ms, bit strap,
                          logic [7:0] hi, logic [7:0] lo, bit drop_irq, int wait_n);
    bit m;
    bit armed;
    m = exp_mon(hv, ms, hi, lo);
    @(negedge clk);
    rst_n = 1'b0; vec_valid = 1'b0; cfg_wd_dis = 1'b0;
    hv_irq = hv; hv_rst = hvr; mode_sel = ms; clk_strap_n = strap;
    vec_byte_hi = hi; vec_byte_lo = lo; cpu_addr = 16'h0000;
    step;
    chk("R9 reset go", cpu_go, 0);
    chk("R9 reset wdog", wdog_en, 0);
    rst_n = 1'b1;
    step; step; step;
    // R1: disturb sampled pins after the sample edge
    mode_sel = ~ms; clk_strap_n = ~strap;
    for (int i = 0; i < wait_n; i++) begin
      chk("R4 waiting req", vec_req, 1);
      chk("R4 waiting go", cpu_go, 0);
      step;
    end
    vec_valid = 1'b1;
    step;
    vec_valid = 1'b0;
    chk("R4 go", cpu_go, 1);
    chk("R4 req drop", vec_req, 0);
    chk("R1 R2 R3 mode", mon_mode, m);
    chk("R5 bypass", clk_bypass, m && !strap);
    // vector window and random addresses
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      a = (k < 4) ? (16'hFFFC + 16'(k)) : 16'($urandom);
      if (k == 4) a = 16'hFEFD;
      if (k == 5) a = 16'hFFFB;
      cpu_addr = a;
      #1;
      chk(m ? "R6 remap" : "R7 pass", vec_addr, exp_addr(m, a));
    end
    armed = 1'b0;
    chk(m ? "R8 mon wdog off" : "R9 user wdog", wdog_en, !m);
    cfg_wd_dis = 1'b1; #1;
    chk("R9 cfg gate", wdog_en, 0);
    cfg_wd_dis = 1'b0;
    if (drop_irq && hv) begin hv_irq = 1'b0; armed = 1'b1; end
    if (!drop_irq && hvr) begin hv_rst = 1'b0; armed = 1'b1; end
    step;
    chk("R8 after removal", wdog_en, !m || armed);
    cfg_wd_dis = 1'b1; #1;
    chk("R8 cfg after removal", wdog_en, 0);
    cfg_wd_dis = 1'b0;
    hi = ~hi; mode_sel = 2'b10; hv_irq = 1'b1; clk_strap_n = 1'b0;
    step; step;
    chk("R10 mode held", mon_mode, m);
    chk("R10 bypass held", clk_bypass, m && !strap);
    chk("R10 go held", cpu_go, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; hv_irq = 0; hv_rst = 0; mode_sel = 0; clk_strap_n = 1;
    vec_valid = 0; vec_byte_hi = 0; vec_byte_lo = 0; cfg_wd_dis = 0; cpu_addr = 0;
    // directed corners
    scenario(0, 0, 2'b10, 1, 8'h12, 8'h34, 1, 2);   // user mode
    scenario(1, 0, 2'b10, 0, 8'h12, 8'h34, 1, 3);   // R2 entry, bypass, irq drop
    scenario(0, 1, 2'b00, 1, 8'hFF, 8'hFF, 0, 1);   // R3 erased, reset-pin drop
    scenario(1, 0, 2'b01, 0, 8'hFF, 8'hFE, 1, 4);   // wrong pins, half erased -> user
    scenario(0, 0, 2'b11, 0, 8'hFF, 8'hFF, 1, 0);   // erased, no HV: never armed
    for (int n = 0; n < 10; n++) begin
      bit hv, hvr, st;
      logic [1:0] ms;
      logic [7:0] hi, lo;
      hv = 1'($urandom); hvr = 1'($urandom); st = 1'($urandom);
      ms = 2'($urandom);
      hi = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      lo = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
      scenario(hv, hvr, ms, st, hi, lo, 1'($urandom), int'($urandom % 5));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not complete");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule